// File: doc/BRIEF.md
# Six-Step Microcode Control Sequencer

This block is the control unit of a small accumulator datapath with 8-bit words. It holds a free-running step counter that moves through a fixed instruction cycle of six steps. In each step it combines the current step, the 3-bit operation code from the instruction register and the registered equal-zero flag into a 15-bit word of datapath strobes. The strobes are the load and drive enables for registers A and B, drive, increment and jump for the program counter, address-register load, RAM write and read, ALU drive and ALU subtract, instruction-register load and drive, and flag load.

Steps 0 and 1 fetch the instruction and are the same for every code. Steps 2 to 5 run the instruction. Each instruction uses a fixed number of these steps, and any step it does not use carries an all-zero word. The conditional jump gives its strobes only while the zero flag is set. The control word and the step index that goes with it are both registered. The word for step s appears one clock edge after that edge sampled the opcode and the flag.

Top module: `uctrl_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `ctrl_o` and `step_o` become zero after that edge, and the internal step restarts at 0. The first edge with `rst` low then presents step 0.
- R2: At each rising edge with `rst` low, `step_o` takes the internal step and `ctrl_o` takes that step's word, decoded from `opcode_i` and `zero_flag_i` sampled at the same edge. The steps run 0,1,2,3,4,5 and then return to 0.
- R3: `ctrl_o` bit positions are: 0 A load, 1 A drive, 2 B load, 3 B drive, 4 PC drive, 5 PC increment, 6 PC jump, 7 address load, 8 RAM write, 9 RAM drive, 10 ALU drive, 11 ALU subtract, 12 IR load, 13 IR drive, 14 flag load. For every opcode, step 0 sets bits 4 and 7, and step 1 sets bits 9, 12 and 5.
- R4: Opcode 0 (load from memory) sets bits 13 and 7 in step 2 and bits 9 and 0 in step 3. Opcode 1 (load immediate) sets bits 13 and 0 in step 2.
- R5: Opcode 2 (store) sets bits 13 and 7 in step 2 and bits 1 and 8 in step 3.
- R6: Opcode 3 (swap through memory) sets bits 13 and 7 in step 2, bits 1 and 8 in step 3, bits 3 and 0 in step 4, and bits 9 and 2 in step 5.
- R7: Opcode 4 (jump) sets bits 13 and 6 in step 2. Opcode 5 (jump if zero) sets bits 13 and 6 in step 2 only when `zero_flag_i` is 1. With the flag at 0 that step is all zero.
- R8: Opcodes 6 (add) and 7 (subtract) set bits 13 and 7 in step 2, bits 9 and 2 in step 3, and bits 10, 0 and 14 in step 4. Opcode 7 also sets bit 11 in step 4.
- R9: Any step from 2 to 5 that R4 to R8 do not list for an opcode gives an all-zero `ctrl_o`.
- R10: At most one of the bus-driving bits (1, 3, 4, 9, 10, 13) is set in any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 3 | Operation code from the instruction register |
| zero_flag_i | input | 1 | Registered equal-zero flag |
| ctrl_o | output | 15 | Registered control word, bit map in R3 |
| step_o | output | 3 | Step index that the current `ctrl_o` belongs to |

## Verification
Two functions can land in the same cycle: the step-counter wrap and a reset, and the conditional-jump gating and a flag that changes at the very edge that decodes step 2. The bench changes the opcode and the flag on every cycle in the random phase. It also asserts reset halfway through an instruction. It judges each cycle against a step count and word table that it keeps itself. Every cycle is checked for a single bus driver, across all opcodes, steps and both flag values.

// File: rtl/uctrl_pkg.sv
package uctrl_pkg;
  localparam int NUM_STEPS = 6;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int OP_W      = 3;
  localparam int CTRL_W    = 15;

  // control word bit positions
  localparam int B_A_LOAD    = 0;
  localparam int B_A_DRIVE   = 1;
  localparam int B_B_LOAD    = 2;
  localparam int B_B_DRIVE   = 3;
  localparam int B_PC_DRIVE  = 4;
  localparam int B_PC_INC    = 5;
  localparam int B_PC_JUMP   = 6;
  localparam int B_MAR_LOAD  = 7;
  localparam int B_RAM_WRITE = 8;
  localparam int B_RAM_DRIVE = 9;
  localparam int B_ALU_DRIVE = 10;
  localparam int B_ALU_SUB   = 11;
  localparam int B_IR_LOAD   = 12;
  localparam int B_IR_DRIVE  = 13;
  localparam int B_FLAG_LOAD = 14;

  localparam logic [CTRL_W-1:0] BUS_DRIVER_MASK =
    (CTRL_W'(1) << B_A_DRIVE)   | (CTRL_W'(1) << B_B_DRIVE)   |
    (CTRL_W'(1) << B_PC_DRIVE)  | (CTRL_W'(1) << B_RAM_DRIVE) |
    (CTRL_W'(1) << B_ALU_DRIVE) | (CTRL_W'(1) << B_IR_DRIVE);

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_LOADI = 3'd1,
    OP_STORE = 3'd2,
    OP_SWAP  = 3'd3,
    OP_JUMP  = 3'd4,
    OP_JUMPZ = 3'd5,
    OP_ADD   = 3'd6,
    OP_SUB   = 3'd7
  } opcode_e;
endpackage

// File: rtl/uctrl_step_counter.sv
module uctrl_step_counter #(
  parameter int NUM_STEPS = 6,
  localparam int STEP_W = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst)               step <= '0;
    else if (step == LAST) step <= '0;
    else                   step <= step + 1'b1;
  end

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    step <= LAST); // R2
endmodule

// File: rtl/uctrl_decoder.sv
module uctrl_decoder
  import uctrl_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [OP_W-1:0]   opcode,
  input  logic              zero_flag,
  output logic [CTRL_W-1:0] word
);
  opcode_e op;
  assign op = opcode_e'(opcode);

  always_comb begin
    word = '0;
    unique case (step)
      3'd0: begin
        word[B_PC_DRIVE] = 1'b1;
        word[B_MAR_LOAD] = 1'b1;
      end
      3'd1: begin
        word[B_RAM_DRIVE] = 1'b1;
        word[B_IR_LOAD]   = 1'b1;
        word[B_PC_INC]    = 1'b1;
      end
      3'd2: begin
        unique case (op)
          OP_LOADI: begin
            word[B_IR_DRIVE] = 1'b1;
            word[B_A_LOAD]   = 1'b1;
          end
          OP_JUMP: begin
            word[B_IR_DRIVE] = 1'b1;
            word[B_PC_JUMP]  = 1'b1;
          end
          OP_JUMPZ: begin
            word[B_IR_DRIVE] = zero_flag;
            word[B_PC_JUMP]  = zero_flag;
          end
          default: begin
            word[B_IR_DRIVE] = 1'b1;
            word[B_MAR_LOAD] = 1'b1;
          end
        endcase
      end
      3'd3: begin
        unique case (op)
          OP_LOAD: begin
            word[B_RAM_DRIVE] = 1'b1;
            word[B_A_LOAD]    = 1'b1;
          end
          OP_STORE, OP_SWAP: begin
            word[B_A_DRIVE]   = 1'b1;
            word[B_RAM_WRITE] = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            word[B_RAM_DRIVE] = 1'b1;
            word[B_B_LOAD]    = 1'b1;
          end
          default: ;
        endcase
      end
      3'd4: begin
        unique case (op)
          OP_SWAP: begin
            word[B_B_DRIVE] = 1'b1;
            word[B_A_LOAD]  = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            word[B_ALU_DRIVE] = 1'b1;
            word[B_A_LOAD]    = 1'b1;
            word[B_FLAG_LOAD] = 1'b1;
            word[B_ALU_SUB]   = (op == OP_SUB);
          end
          default: ;
        endcase
      end
      3'd5: begin
        if (op == OP_SWAP) begin
          word[B_RAM_DRIVE] = 1'b1;
          word[B_B_LOAD]    = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uctrl_sequencer.sv
module uctrl_sequencer
  import uctrl_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [2:0]                   opcode_i,
  input  logic                         zero_flag_i,
  output logic [uctrl_pkg::CTRL_W-1:0] ctrl_o,
  output logic [uctrl_pkg::STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] step_cur;
  logic [CTRL_W-1:0] word_next;

  uctrl_step_counter #(.NUM_STEPS(NUM_STEPS)) u_steps (
    .clk  (clk),
    .rst  (rst),
    .step (step_cur)
  );

  uctrl_decoder u_dec (
    .step      (step_cur),
    .opcode    (opcode_i),
    .zero_flag (zero_flag_i),
    .word      (word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      step_o <= '0;
    end else begin
      ctrl_o <= word_next;
      step_o <= step_cur;
    end
  end

  localparam logic [CTRL_W-1:0] FETCH0 =
    (CTRL_W'(1) << B_PC_DRIVE) | (CTRL_W'(1) << B_MAR_LOAD);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_o == '0 && step_o == '0)); // R1
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && step_o == STEP_W'(NUM_STEPS - 1)) |=> step_o == '0); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && step_o != STEP_W'(NUM_STEPS - 1)) |=> step_o == $past(step_o) + 1'b1); // R2
  AST_FETCH_WORD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && step_o == '0) |-> ctrl_o == FETCH0); // R3
  AST_JUMP_GATED: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[B_PC_JUMP] |-> ($past(opcode_i) == OP_JUMP ||
                           ($past(opcode_i) == OP_JUMPZ && $past(zero_flag_i)))); // R7
  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl_o & BUS_DRIVER_MASK) <= 1); // R10
endmodule

// File: tb/uctrl_sequencer_bench.sv
module uctrl_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  opcode_i;
  logic        zero_flag_i;
  logic [14:0] ctrl_o;
  logic [2:0]  step_o;

  always #5 clk = ~clk;

  uctrl_sequencer u_uctrl_sequencer (
    .clk(clk), .rst(rst), .opcode_i(opcode_i), .zero_flag_i(zero_flag_i),
    .ctrl_o(ctrl_o), .step_o(step_o)
  );

  int errors = 0;
  int checks = 0;
  int model_step = 0;
  logic [14:0] exp_word;
  int exp_step;
  bit exp_in_reset;
  int exp_op;
  bit primed = 0;
  bit done = 0;

  function automatic logic [14:0] bits(input int a, input int b, input int c = -1, input int d = -1);
    logic [14:0] w = '0;
    w[a] = 1'b1; w[b] = 1'b1;
    if (c >= 0) w[c] = 1'b1;
    if (d >= 0) w[d] = 1'b1;
    return w;
  endfunction

  function automatic logic [14:0] ref_word(input int op, input int st, input bit z);
    if (st == 0) return bits(4, 7);
    if (st == 1) return bits(9, 12, 5);
    case (op)
      0: if (st == 2) return bits(13, 7); else if (st == 3) return bits(9, 0);
      1: if (st == 2) return bits(13, 0);
      2: if (st == 2) return bits(13, 7); else if (st == 3) return bits(1, 8);
      3: case (st)
           2: return bits(13, 7);
           3: return bits(1, 8);
           4: return bits(3, 0);
           default: return bits(9, 2);
         endcase
      4: if (st == 2) return bits(13, 6);
      5: if (st == 2 && z) return bits(13, 6);
      default: if (st == 2) return bits(13, 7);
               else if (st == 3) return bits(9, 2);
               else if (st == 4) return (op == 7) ? bits(10, 0, 14, 11) : bits(10, 0, 14);
    endcase
    return '0;
  endfunction

  function automatic string tag_for(input bit in_rst, input int op, input int st, input logic [14:0] w);
    if (in_rst) return "R1";
    if (st < 2) return "R3";
    if (w == '0) return (op == 5) ? "R7" : "R9";
    case (op)
      0, 1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    exp_in_reset <= rst;
    exp_op <= int'(opcode_i);
    if (rst) begin
      exp_word <= '0; exp_step <= 0; model_step = 0;
    end else begin
      exp_word <= ref_word(int'(opcode_i), model_step, zero_flag_i);
      exp_step <= model_step;
      model_step = (model_step + 1) % 6;
    end
    primed <= 1'b1;
  end

  always @(negedge clk) begin
    if (primed && !done) begin
      int nbus;
      checks++;
      if (ctrl_o !== exp_word) begin
        errors++;
        $display("FAIL %s op=%0d step=%0d ctrl actual=%h expected=%h",
                 tag_for(exp_in_reset, exp_op, exp_step, exp_word), exp_op, exp_step, ctrl_o, exp_word);
      end
      checks++;
      if (int'(step_o) != exp_step) begin
        errors++;
        $display("FAIL %s step actual=%0d expected=%0d", exp_in_reset ? "R1" : "R2", step_o, exp_step);
      end
      nbus = int'(ctrl_o[1]) + int'(ctrl_o[3]) + int'(ctrl_o[4]) +
             int'(ctrl_o[9]) + int'(ctrl_o[10]) + int'(ctrl_o[13]);
      checks++;
      if (nbus > 1) begin
        errors++;
        $display("FAIL R10 bus drivers actual=%0d expected<=1", nbus);
      end
    end
  end

  task automatic sweep();
    for (int op = 0; op < 8; op++)
      for (int z = 0; z < 2; z++)
        for (int s = 0; s < 6; s++) begin
          @(negedge clk);
          opcode_i = 3'(op); zero_flag_i = z[0];
        end
  endtask

  initial begin
    logic [7:0] lfsr = 8'hA5;
    rst = 1'b1; opcode_i = 3'd0; zero_flag_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sweep();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      opcode_i = lfsr[2:0]; zero_flag_i = lfsr[6];
    end
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sweep();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule